// File: doc/BRIEF.md
# Zero-Extending Widening Lane Shifter

This block takes half of a 128-bit vector and widens each of its lanes. A control flag picks the upper or the lower 64 bits. Each narrow lane in that half is zero-extended to twice its width and shifted left by an amount taken from a 7-bit immediate. The widened lanes are packed into a 128-bit result.

A 2-bit size code selects the narrow lane width: 8, 16 or 32 bits. The output lanes are therefore 16, 32 or 64 bits wide, and there are always enough of them to fill the full 128 bits. The immediate encodes the lane width plus the shift, so the shift is the immediate minus the narrow lane width.

Inputs are sampled when the input valid strobe is high. The result, an error flag and an output valid strobe appear one clock later. An illegal size code or an out-of-range immediate gives an all-zero result with the error flag set.

Top module: `widenShiftUnit`

## Requirements
- R1: When `upperHalf` is 1 the source lanes come from `srcVec[127:64]`; when it is 0 they come from `srcVec[63:0]`.
- R2: Each source lane is zero-extended before shifting. Bits of an output lane not covered by the shifted source lane are 0, whatever the value of the lane's top bit.
- R3: With narrow width W = 8 << `sizeCode` (sizeCode 0, 1, 2 give W = 8, 16, 32), source lane i is taken from bits [i*W +: W] of the selected half. It is shifted left by `immVal` - W and placed in `outData[i*2W +: 2W]`.
- R4: There are 8 >> `sizeCode` output lanes of width 2W, and together they fill all 128 bits of `outData`.
- R5: `sizeCode` 3 is illegal. The captured result has `outErr` = 1 and `outData` = 0.
- R6: An `immVal` below W or at or above 2W is illegal. The captured result has `outErr` = 1 and `outData` = 0. A legal combination gives `outErr` = 0.
- R7: `outValid` is 1 in exactly the cycle after a cycle with `inValid` = 1, and 0 otherwise.
- R8: While `inValid` is 0, `outData` and `outErr` keep their values, whatever the other inputs do.
- R9: While `rstN` is low, `outValid`, `outErr` and `outData` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| sizeCode | input | 2 | Narrow lane width code (0: 8, 1: 16, 2: 32 bits, 3: illegal) |
| immVal | input | 7 | Immediate: narrow width plus the shift amount |
| upperHalf | input | 1 | 1 selects source bits 127:64, 0 selects bits 63:0 |
| srcVec | input | 128 | Source vector |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| outData | output | 128 | Widened and shifted result |
| outErr | output | 1 | Illegal size code or immediate |

## Verification
The bench builds the block with its default parameters: a 128-bit vector, a 2-bit size code and a 7-bit immediate. At this size the whole control space can be covered. Every size code, every one of the 128 immediate values and both half selections are each paired with three source patterns. Each pattern has lanes with the top bit set, so a sign fill would be caught. Every legal shift, both edges of each legal immediate range and the illegal codes are all reached. After each result the bench scrambles the inputs with the strobe low, which exercises the hold behaviour.

// File: rtl/widenShiftPkg.sv
package widenShiftPkg;
  parameter int VEC_W  = 128;
  parameter int SIZE_W = 2;
  parameter int IMM_W  = 7;
  parameter int HALF_W = VEC_W / 2;
  // narrow widths 8 .. HALF_W/2
  parameter int NUM_SIZES = $clog2(HALF_W / 8);
  parameter int SH_W   = $clog2(HALF_W / 2);

  typedef struct packed {
    logic              load;
    logic              errFlag;
    logic              upperSel;
    logic [SIZE_W-1:0] sizeSel;
    logic [SH_W-1:0]   shAmt;
  } ctrlStrobes_t;
endpackage

// File: rtl/widenShiftCtrl.sv
module widenShiftCtrl
  import widenShiftPkg::*;
(
  input  logic              inValid,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              upperHalf,
  output ctrlStrobes_t      ctrl
);
  localparam int EXT_W = IMM_W + 1;

  logic [EXT_W-1:0] laneW;
  logic [EXT_W-1:0] immExt;
  logic [EXT_W-1:0] shDiff;
  logic             sizeOk;
  logic             immOk;

  always_comb begin
    laneW  = EXT_W'(8) << sizeCode;
    immExt = {1'b0, immVal};
    shDiff = immExt - laneW;
    sizeOk = sizeCode < SIZE_W'(NUM_SIZES);
    immOk  = (immExt >= laneW) && (immExt < (laneW << 1));
    ctrl.load     = inValid;
    ctrl.errFlag  = !(sizeOk && immOk);
    ctrl.upperSel = upperHalf;
    ctrl.sizeSel  = sizeCode;
    ctrl.shAmt    = shDiff[SH_W-1:0];
  end
endmodule

// File: rtl/widenShiftData.sv
module widenShiftData
  import widenShiftPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctrl,
  input  logic [VEC_W-1:0] srcVec,
  output logic             outValid,
  output logic [VEC_W-1:0] outData,
  output logic             outErr
);
  logic [HALF_W-1:0]                 halfSel;
  logic [NUM_SIZES-1:0][VEC_W-1:0]   perSize;
  logic [VEC_W-1:0]                  resultNext;

  assign halfSel = ctrl.upperSel ? srcVec[VEC_W-1:HALF_W] : srcVec[HALF_W-1:0];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = HALF_W / LW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [2*LW-1:0] wideLane;
      assign wideLane = {{LW{1'b0}}, halfSel[i*LW +: LW]} << ctrl.shAmt;
      assign perSize[s][i*2*LW +: 2*LW] = wideLane;
    end
  end

  always_comb begin
    resultNext = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (ctrl.sizeSel == SIZE_W'(s)) resultNext = perSize[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outErr  <= ctrl.errFlag;
        outData <= ctrl.errFlag ? '0 : resultNext;
      end
    end
  end
endmodule

// File: rtl/widenShiftUnit.sv
module widenShiftUnit
  import widenShiftPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              upperHalf,
  input  logic [VEC_W-1:0]  srcVec,
  output logic              outValid,
  output logic [VEC_W-1:0]  outData,
  output logic              outErr
);
  ctrlStrobes_t ctrl;

  widenShiftCtrl u_ctrl (
    .inValid  (inValid),
    .sizeCode (sizeCode),
    .immVal   (immVal),
    .upperHalf(upperHalf),
    .ctrl     (ctrl)
  );

  widenShiftData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcVec  (srcVec),
    .outValid(outValid),
    .outData (outData),
    .outErr  (outErr)
  );
endmodule

// File: rtl/widenShiftChecker.sv
module widenShiftChecker
  import widenShiftPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [SIZE_W-1:0] sizeCode,
  input logic [IMM_W-1:0]  immVal,
  input logic              upperHalf,
  input logic [VEC_W-1:0]  srcVec,
  input logic              outValid,
  input logic [VEC_W-1:0]  outData,
  input logic              outErr
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_bad_size_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd3) |=> (outErr && outData == '0));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outErr) |-> outData == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outData) && $stable(outErr)));

  p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd0 && immVal == 7'd8 && !upperHalf)
      |=> outData[15:0] == {8'h00, $past(srcVec[7:0])});
endmodule

bind widenShiftUnit widenShiftChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .sizeCode (sizeCode),
  .immVal   (immVal),
  .upperHalf(upperHalf),
  .srcVec   (srcVec),
  .outValid (outValid),
  .outData  (outData),
  .outErr   (outErr)
);

// File: tb/sim_widenShiftUnit.sv
module sim_widenShiftUnit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [1:0]   sizeCode;
  logic [6:0]   immVal;
  logic         upperHalf;
  logic [127:0] srcVec;
  logic         outValid;
  logic [127:0] outData;
  logic         outErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  widenShiftUnit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .immVal(immVal), .upperHalf(upperHalf), .srcVec(srcVec),
    .outValid(outValid), .outData(outData), .outErr(outErr)
  );

  // Reference: arithmetic model from the requirements
  function automatic logic [128:0] model(input int sz, input int imm,
                                         input bit up, input logic [127:0] src);
    logic [127:0] res;
    logic [63:0]  half;
    int w, sh;
    res = '0;
    if (sz == 3) return {1'b1, 128'd0};                 // R5
    w = 8 << sz;
    if (imm < w || imm >= 2 * w) return {1'b1, 128'd0}; // R6
    sh = imm - w;
    half = up ? src[127:64] : src[63:0];                // R1
    for (int i = 0; i < 64 / w; i++) begin              // R4
      logic [127:0] lane;
      lane = 128'((half >> (i * w)) & ((64'd1 << w) - 64'd1)); // R2
      res = res | ((lane << sh) << (i * 2 * w));        // R3
    end
    return {1'b0, res};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [127:0] base [3];
    logic [128:0] exp;
    logic [127:0] heldData;
    logic         heldErr;
    base[0] = {128{1'b1}};
    base[1] = 128'h80FF_7F01_8000_FFFE_C3A5_5A3C_8181_0102;
    base[2] = 128'hF00D_8BAD_9E37_79B9_DEAD_BEEF_8765_4321;

    rstN = 1'b0; inValid = 1'b1; sizeCode = 2'd0; immVal = 7'd9;
    upperHalf = 1'b0; srcVec = base[0];
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outErr == 1'b0 && outData == '0, "R9 reset",
          {126'd0, outValid, outErr}, '0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int sz = 0; sz < 4; sz++)
      for (int imm = 0; imm < 128; imm++)
        for (int up = 0; up < 2; up++)
          for (int p = 0; p < 3; p++) begin
            sizeCode  = 2'(sz);
            immVal    = 7'(imm);
            upperHalf = up[0];
            srcVec    = base[p] ^ {4{32'(imm * 32'h9E37_79B9)}};
            inValid   = 1'b1;
            exp = model(sz, imm, up[0], srcVec);
            @(negedge clk);
            check(outValid == 1'b1, "R7 valid after strobe",
                  {127'd0, outValid}, 128'd1);
            if (sz == 3)
              check(outErr == exp[128], "R5 size flag",
                    {127'd0, outErr}, {127'd0, exp[128]});
            else
              check(outErr == exp[128], "R6 immediate flag",
                    {127'd0, outErr}, {127'd0, exp[128]});
            if (up != 0)
              check(outData == exp[127:0], "R1 R2 R3 R4 upper data",
                    outData, exp[127:0]);
            else
              check(outData == exp[127:0], "R2 R3 R4 lower data",
                    outData, exp[127:0]);
            heldData = outData;
            heldErr  = outErr;
            // scramble inputs with strobe low
            inValid   = 1'b0;
            sizeCode  = ~sizeCode;
            immVal    = ~immVal;
            upperHalf = ~upperHalf;
            srcVec    = ~srcVec;
            @(negedge clk);
            check(outValid == 1'b0, "R7 valid drops",
                  {127'd0, outValid}, 128'd0);
            check(outData == heldData && outErr == heldErr, "R8 hold",
                  outData, heldData);
          end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule